// File: doc/BRIEF.md
# Multiply/Divide Register Peripheral

This block is an arithmetic helper for a small microcontroller data bus. It
holds five byte-wide operand registers and one control register, all reached
through a plain byte port: address, write strobe, write data, and
combinational read data. Software loads the operands, then writes a start
request into the control register. The unit either forms the unsigned product
of an 8-bit multiplier and a 16-bit multiplicand (24-bit result), or the
unsigned 16-bit quotient of a 24-bit dividend by a 16-bit divisor. Results go
back into the same byte registers that held the operands.

One instruction cycle is modelled as `CLKS_PER_ICYC` clocks. While an
operation runs, `busy` is high, the register file is locked against bus
writes, and reads return zero. A divide whose quotient cannot fit in 16 bits,
or whose divisor is zero, is flagged and finishes early. The operand registers
are not touched in that case.

Operand register k (k = 1..5) sits at byte address k-1. Multi-byte values are
little-endian, with the lowest-numbered register holding the least
significant byte. The control register is at address 5. Its bit 0 requests a
multiply, bit 1 requests a divide, and bit 2 is the read-only overflow flag.
All other control bits read as zero.

Top module: `muldiv_unit`

## Requirements
- R1: A write to address 5 with bit 0 set (bit 1 clear) multiplies register 2 (address 1) by registers 4–5 (addresses 3–4). The 24-bit product goes to addresses 1–3, least significant byte at address 1. Address 0 and address 4 keep their values, and the overflow flag (control bit 2) reads 0 afterwards.
- R2: A write to address 5 with bit 1 set divides addresses 0–2 (dividend, LSB at 0) by addresses 3–4 (divisor, LSB at 3). When no overflow occurs, the 16-bit quotient goes to addresses 0–1 (LSB at 0), addresses 2–4 keep their values, and the overflow flag reads 0.
- R3: A divide with a zero divisor, or with dividend bits 23..16 greater than or equal to the divisor, sets the overflow flag (control reads 0x04) and leaves all five operand registers unchanged.
- R4: A control write with both bit 0 and bit 1 set performs a divide.
- R5: After the accepting clock edge, `busy` stays high for exactly CLKS_PER_ICYC clocks for a multiply, 2·CLKS_PER_ICYC clocks for a normal divide, and CLKS_PER_ICYC clocks for an overflowing divide. A busy period begins only after a control write that carries a start bit.
- R6: While `busy` is high, writes to any address are ignored: operand registers keep their contents and a control write starts nothing. Reads return 0x00.
- R7: When idle, the control register reads with bits 0, 1 and 3..7 at zero. A control write without start bits starts nothing and cannot set the overflow flag.
- R8: A synchronous active-low reset clears the overflow flag, ends any running operation at once, and leaves `busy` low.
- R9: A set overflow flag does not affect the next operation. A following multiply clears the flag, and a following normal divide clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Byte address: 0–4 operand registers, 5 control |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr`, zero while busy |
| busy | output | 1 | High while an operation is running |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the multiply and divide requests, which arrive together in one control write of 0x03. The bench provokes it from the vector table and judges it by two results: the quotient appears in addresses 0–1, and `busy` lasts the divide length rather than the multiply length. The second pair is a running operation and bus writes aimed at it. The bench writes the divisor high byte and then a fresh multiply request into the cycles of a running divide. It then checks that the byte kept its old value, that the total busy length stayed at two instruction cycles, and that no second operation followed.

// File: rtl/muldiv_pkg.sv
// Shared sizes, register layout and operation type for the multiply/divide
// peripheral. Assumes every operand width is a whole number of bytes.
package muldiv_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int ADDR_W   = 3;

    localparam int MLR_W = 8;              // multiplier
    localparam int MCD_W = 16;             // multiplicand
    localparam int PRD_W = MLR_W + MCD_W;  // product
    localparam int DVD_W = 24;             // dividend
    localparam int DVS_W = 16;             // divisor
    localparam int QUO_W = 16;             // quotient

    // Lowest byte index of each field in the register file.
    localparam int MLR_IDX = 1;
    localparam int MCD_IDX = 3;
    localparam int PRD_IDX = 1;
    localparam int DVD_IDX = 0;
    localparam int DVS_IDX = 3;
    localparam int QUO_IDX = 0;

    localparam logic [ADDR_W-1:0] LAST_REG  = ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

    localparam int CTL_MUL_BIT = 0;
    localparam int CTL_DIV_BIT = 1;
    localparam int CTL_OVF_BIT = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_MUL  = 2'd1,
        OP_DIV  = 2'd2
    } op_e;
endpackage

// File: rtl/muldiv_mult.sv
// Unsigned shift-and-add multiplier, purely combinational.
// Assumes P_W >= A_W + B_W so that no product bit is lost.
module muldiv_mult #(
    parameter int A_W = 8,
    parameter int B_W = 16,
    parameter int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);
    logic [P_W-1:0] pp [A_W];

    // One shifted copy of b per multiplier bit.
    for (genvar i = 0; i < A_W; i++) begin : g_pp
        assign pp[i] = a[i] ? ({{(P_W-B_W){1'b0}}, b} << i) : '0;
    end

    // Sum of the partial products.
    always_comb begin
        p = '0;
        for (int i = 0; i < A_W; i++) begin
            p = p + pp[i];
        end
    end
endmodule

// File: rtl/muldiv_div.sv
// Unsigned restoring divider, one array stage per quotient bit, purely
// combinational. Flags a zero divisor or a quotient wider than Q_W bits.
// The quotient is meaningful only when ovf is low.
// Assumes NUM_W - Q_W < DEN_W.
module muldiv_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 16,
    parameter int Q_W   = 16
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo,
    output logic             ovf
);
    localparam int HI_W = NUM_W - Q_W;

    logic [DEN_W-1:0] rem [Q_W];

    // Upper dividend bits start the partial remainder.
    assign rem[0] = {{(DEN_W-HI_W){1'b0}}, num[NUM_W-1:Q_W]};
    // The quotient fits only if the upper bits are below the divisor.
    assign ovf    = (den == '0) || (rem[0] >= den);

    for (genvar i = 0; i < Q_W; i++) begin : g_step
        logic [DEN_W:0] trial;
        assign trial = {rem[i], num[Q_W-1-i]};
        if (i < Q_W - 1) begin : g_mid
            logic [DEN_W:0] diff;
            // Subtract; the borrow bit tells whether the divisor fitted.
            assign diff       = trial - {1'b0, den};
            assign quo[Q_W-1-i] = ~diff[DEN_W];
            assign rem[i+1]   = diff[DEN_W] ? trial[DEN_W-1:0] : diff[DEN_W-1:0];
        end else begin : g_last
            // The last stage needs only the compare.
            assign quo[Q_W-1-i] = (trial >= {1'b0, den});
        end
    end
endmodule

// File: rtl/muldiv_seq.sv
// Operation sequencer: accepts a start request when idle, chooses divide
// over multiply, and times the run in clocks. done marks its last cycle.
// Assumes CYC >= 1 and that div_ovf is stable for the whole run.
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic req_mul,
    input  logic req_div,
    input  logic div_ovf,
    output logic busy,
    output logic done,
    output op_e  cur_op
);
    localparam int CNT_W = (CYC > 1) ? $clog2(2 * CYC) : 1;
    localparam logic [CNT_W-1:0] SHORT_RUN = CNT_W'(CYC - 1);
    localparam logic [CNT_W-1:0] LONG_RUN  = CNT_W'(2 * CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Start, count down and finish an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op <= OP_IDLE;
            cnt    <= '0;
        end else if (cur_op == OP_IDLE) begin
            if (launch && req_div) begin
                cur_op <= OP_DIV;
                cnt    <= div_ovf ? SHORT_RUN : LONG_RUN;
            end else if (launch && req_mul) begin
                cur_op <= OP_MUL;
                cnt    <= SHORT_RUN;
            end
        end else if (cnt == '0) begin
            cur_op <= OP_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cur_op != OP_IDLE);
    assign done = busy && (cnt == '0);
endmodule

// File: rtl/muldiv_unit.sv
// Memory-mapped multiply/divide unit. Five byte registers hold operands and
// results; the control register at CTRL_ADDR starts an operation and shows
// the divide overflow flag. Bus writes are ignored and reads return zero
// while busy. The operand registers have no reset; their contents after
// reset are undefined to software.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int CLKS_PER_ICYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy
);
    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic              ovf_q;
    logic              done;
    op_e               cur_op;
    logic              reg_wr;
    logic              ctrl_wr;
    logic [MLR_W-1:0]  mlr;
    logic [MCD_W-1:0]  mcd;
    logic [PRD_W-1:0]  prd;
    logic [DVD_W-1:0]  dvd;
    logic [DVS_W-1:0]  dvs;
    logic [QUO_W-1:0]  quo;
    logic              div_ovf;

    // Bus writes are accepted only when idle.
    assign reg_wr  = wr_en && !busy && (addr <= LAST_REG);
    assign ctrl_wr = wr_en && !busy && (addr == CTRL_ADDR);

    // Assemble operands from the byte registers.
    always_comb begin
        mlr = regs[MLR_IDX];
        for (int k = 0; k < MCD_W / BYTE_W; k++) mcd[k*BYTE_W +: BYTE_W] = regs[MCD_IDX + k];
        for (int k = 0; k < DVD_W / BYTE_W; k++) dvd[k*BYTE_W +: BYTE_W] = regs[DVD_IDX + k];
        for (int k = 0; k < DVS_W / BYTE_W; k++) dvs[k*BYTE_W +: BYTE_W] = regs[DVS_IDX + k];
    end

    muldiv_mult #(.A_W(MLR_W), .B_W(MCD_W), .P_W(PRD_W)) u_mult (
        .a(mlr), .b(mcd), .p(prd)
    );

    muldiv_div #(.NUM_W(DVD_W), .DEN_W(DVS_W), .Q_W(QUO_W)) u_div (
        .num(dvd), .den(dvs), .quo(quo), .ovf(div_ovf)
    );

    muldiv_seq #(.CYC(CLKS_PER_ICYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (ctrl_wr),
        .req_mul (wr_data[CTL_MUL_BIT]),
        .req_div (wr_data[CTL_DIV_BIT]),
        .div_ovf (div_ovf),
        .busy    (busy),
        .done    (done),
        .cur_op  (cur_op)
    );

    // Register file: bus writes when idle, result write-back on completion.
    always_ff @(posedge clk) begin
        if (reg_wr) begin
            regs[addr] <= wr_data;
        end else if (rst_n && done && cur_op == OP_MUL) begin
            for (int k = 0; k < PRD_W / BYTE_W; k++) regs[PRD_IDX + k] <= prd[k*BYTE_W +: BYTE_W];
        end else if (rst_n && done && cur_op == OP_DIV && !div_ovf) begin
            for (int k = 0; k < QUO_W / BYTE_W; k++) regs[QUO_IDX + k] <= quo[k*BYTE_W +: BYTE_W];
        end
    end

    // Overflow flag: each divide sets or clears it, each multiply clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (done) ovf_q <= (cur_op == OP_DIV) ? div_ovf : 1'b0;
    end

    // Read mux; blank while busy, start bits always read back as zero.
    always_comb begin
        rd_data = '0;
        if (!busy) begin
            if (addr <= LAST_REG)        rd_data = regs[addr];
            else if (addr == CTRL_ADDR)  rd_data[CTL_OVF_BIT] = ovf_q;
        end
    end
endmodule

// File: rtl/muldiv_unit_chk.sv
// Protocol checker for muldiv_unit, bound to every instance. It watches only
// the bus port and the busy output, and counts busy run lengths itself.
module muldiv_unit_chk
    import muldiv_pkg::*;
#(
    parameter int CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [1:0]        start_bits,
    input logic [BYTE_W-1:0] rd_data,
    input logic              busy
);
    localparam logic [BYTE_W-1:0] CTRL_LIVE = BYTE_W'(1) << CTL_OVF_BIT;

    logic [31:0] run_len;

    // Length of the current or just-ended busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    // R6: reads are blank during an operation.
    p_rd_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data == '0));

    // R5: a run starts only after an accepted control write with a start bit.
    p_launch_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == CTRL_ADDR && start_bits != 2'b00));

    // R5: no run is longer than two instruction cycles.
    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < 32'(2 * CYC)));

    // R5: a finished run lasted one or two instruction cycles.
    p_run_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_len != 0) |-> (run_len == 32'(CYC) || run_len == 32'(2 * CYC)));

    // R7: idle control reads show only the overflow bit.
    p_ctrl_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && addr == CTRL_ADDR) |-> ((rd_data & ~CTRL_LIVE) == '0));
endmodule

bind muldiv_unit muldiv_unit_chk #(.CYC(CLKS_PER_ICYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .start_bits (wr_data[1:0]),
    .rd_data    (rd_data),
    .busy       (busy)
);

// File: tb/muldiv_unit_tb.sv
// Self-checking bench: vector table walk, then directed lockout/reset cases.
module muldiv_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OP_CYC     = 2;
    localparam int NVEC       = 10;

    // {op(1=mul,2=div,3=both), a[23:0], b[15:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {2'd1, 24'h0000FF, 16'hFFFF},
        {2'd2, 24'h123456, 16'h0100},
        {2'd2, 24'h00FFFF, 16'h0001},
        {2'd2, 24'h010000, 16'h0001},
        {2'd1, 24'h000012, 16'h0001},
        {2'd2, 24'h123456, 16'h0000},
        {2'd2, 24'hFFFFFF, 16'hFFFF},
        {2'd3, 24'h000064, 16'h0007},
        {2'd1, 24'h000000, 16'h1234},
        {2'd2, 24'h000005, 16'h0009}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy;
    int         checks = 0;
    int         failures = 0;

    muldiv_unit #(.CLKS_PER_ICYC(OP_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; wr_en = 1'b0;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [7:0]  ld [5];
        logic [7:0]  ex [5];
        logic [1:0]  op;
        logic [23:0] a;
        logic [15:0] b;
        int unsigned res;
        int          n;
        int          n2;
        logic        ovf;
        logic        prev_ovf;
        string       tag;
        string       ctag;

        // Reset state (R8)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "busy after reset", 32'(busy), 0);
        bus_rd(3'd5, v);
        check("R8", "control after reset", 32'(v), 0);

        // Control write without start bits (R7)
        bus_wr(3'd5, 8'hFC);
        check("R7", "busy after non-start write", 32'(busy), 0);
        bus_rd(3'd5, v);
        check("R7", "control after non-start write", 32'(v), 0);

        // Vector walk (R1 R2 R3 R4 R5 R9)
        prev_ovf = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            op = VEC[i][41:40];
            a  = VEC[i][39:16];
            b  = VEC[i][15:0];
            if (op == 2'd1) begin
                ld[0] = 8'h5A; ld[1] = a[7:0]; ld[2] = 8'hC3;
            end else begin
                ld[0] = a[7:0]; ld[1] = a[15:8]; ld[2] = a[23:16];
            end
            ld[3] = b[7:0]; ld[4] = b[15:8];
            for (int k = 0; k < 5; k++) bus_wr(3'(k), ld[k]);
            bus_wr(3'd5, (op == 2'd1) ? 8'h01 : ((op == 2'd3) ? 8'h03 : 8'h02));
            wait_idle(n);
            for (int k = 0; k < 5; k++) ex[k] = ld[k];
            if (op == 2'd1) begin
                res = 32'(a[7:0]) * 32'(b);
                ex[1] = res[7:0]; ex[2] = res[15:8]; ex[3] = res[23:16];
                ovf = 1'b0;
                tag = "R1";
                check("R5", "multiply busy length", 32'(n), OP_CYC);
            end else begin
                ovf = (b == 16'h0) || ((32'(a) / 32'(b)) > 32'hFFFF);
                if (!ovf) begin
                    res = 32'(a) / 32'(b);
                    ex[0] = res[7:0]; ex[1] = res[15:8];
                end
                tag = (op == 2'd3) ? "R4" : (ovf ? "R3" : "R2");
                check("R5", "divide busy length", 32'(n), ovf ? OP_CYC : 2 * OP_CYC);
            end
            for (int k = 0; k < 5; k++) begin
                bus_rd(3'(k), v);
                check(tag, $sformatf("vector %0d register %0d", i, k), 32'(v), 32'(ex[k]));
            end
            ctag = (prev_ovf && !ovf) ? "R9" : tag;
            bus_rd(3'd5, v);
            check(ctag, $sformatf("vector %0d control", i), 32'(v), ovf ? 32'h04 : 32'h00);
            prev_ovf = ovf;
        end

        // Lockout during a divide (R6): 0x000100 / 0x0002 = 0x0080
        bus_wr(3'd0, 8'h00); bus_wr(3'd1, 8'h01); bus_wr(3'd2, 8'h00);
        bus_wr(3'd3, 8'h02); bus_wr(3'd4, 8'h00);
        @(negedge clk);
        addr = 3'd5; wr_data = 8'h02; wr_en = 1'b1;
        @(negedge clk);
        addr = 3'd4; wr_data = 8'hEE; wr_en = 1'b1;
        #1;
        check("R6", "read while busy", 32'(rd_data), 0);
        @(negedge clk);
        addr = 3'd5; wr_data = 8'h01; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle(n2);
        check("R6", "divide length with writes in flight", 32'(n2 + 2), 2 * OP_CYC);
        @(negedge clk);
        check("R6", "no operation from locked control write", 32'(busy), 0);
        bus_rd(3'd4, v);
        check("R6", "locked register kept", 32'(v), 32'h00);
        bus_rd(3'd0, v);
        check("R6", "quotient low byte", 32'(v), 32'h80);

        // Reset aborts an operation and clears the flag (R8)
        bus_wr(3'd0, 8'h00); bus_wr(3'd1, 8'h00); bus_wr(3'd2, 8'h01);
        bus_wr(3'd3, 8'h01); bus_wr(3'd4, 8'h00);
        bus_wr(3'd5, 8'h02);
        wait_idle(n);
        bus_rd(3'd5, v);
        check("R3", "overflow flag before reset", 32'(v), 32'h04);
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd5, 8'h02);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R8", "busy after reset mid-run", 32'(busy), 0);
        bus_rd(3'd5, v);
        check("R8", "flag cleared by reset", 32'(v), 0);
        repeat (2 * OP_CYC) @(negedge clk);
        check("R8", "operation not resumed", 32'(busy), 0);

        summary();
        $finish;
    end
endmodule